// File: doc/BRIEF.md
# Multi-Word Alarm Annunciator With Acknowledge

This block supervises a bank of alarm inputs, grouped in words of `WORD_W` bits with `NUM_WORDS` words side by side, and presents them the way a lamp-board annunciator does. Every clock is one evaluation step, and in that step all alarm bits are updated together with bitwise logic. An alarm that is raised for a single step is held as unacknowledged until an operator acknowledges it. The block keeps the unacknowledged and acknowledged bit words as state. The current-alarm word is their union.

Each alarm drives one lamp. The lamp flashes while the alarm waits for acknowledgement. It is lit steadily once the alarm is acknowledged and still active, and it goes dark once the alarm is acknowledged and has cleared. The flash phase is a square wave that inverts on each `flash_tick_i` strobe. A strobe every half second gives 0.5 s on and 0.5 s off. A single horn output is high whenever any alarm in any word is unacknowledged.

Top module: `alm_annunciator`

## Requirements
- R1: While reset is asserted and after its release, before any alarm, the unacknowledged, acknowledged and current words are all zero, every lamp is dark and the horn is low.
- R2: An alarm bit that is high on `raw_i` while its acknowledged bit is clear sets its unacknowledged bit at the next clock edge, unless an acknowledge edge occurs in that step. The unacknowledged bit stays set after the raw bit falls, even when the raw bit was high for a single cycle, until the next acknowledge edge.
- R3: `cur_o` equals the bitwise OR of `unack_o` and `acked_o` at all times. An unacknowledged bit and an acknowledged bit for the same alarm are never set together.
- R4: On a rising edge of `ack_i`, the acknowledged word takes every alarm whose raw bit is high in that step, and the unacknowledged word is cleared.
- R5: Keeping `ack_i` high after its rising edge acknowledges nothing more: an alarm raised while the button is held becomes unacknowledged.
- R6: An acknowledged bit clears at the edge after its raw bit falls. A later rise of that raw bit latches the alarm as unacknowledged again.
- R7: Lamp bit i is `(unack_o[i] AND flash phase) OR acked_o[i]`: flashing while unacknowledged, steady while acknowledged and active, dark otherwise.
- R8: The flash phase is 0 after reset and inverts at each clock edge at which `flash_tick_i` is high.
- R9: `horn_o` is high exactly when at least one bit of `unack_o` is set, across all words.
- R10: Alarm bit i belongs to word i / `WORD_W`. Bits in different words are captured, acknowledged and lit independently, with the same rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one evaluation step per edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | WORD_W*NUM_WORDS | Raw alarm conditions, 1 = abnormal |
| ack_i | input | 1 | Acknowledge push button level |
| flash_tick_i | input | 1 | Strobe that inverts the flash phase |
| cur_o | output | WORD_W*NUM_WORDS | Current alarms, acknowledged or not |
| acked_o | output | WORD_W*NUM_WORDS | Acknowledged alarms still active |
| unack_o | output | WORD_W*NUM_WORDS | Alarms awaiting acknowledgement |
| lamp_o | output | WORD_W*NUM_WORDS | Lamp drive per alarm |
| horn_o | output | 1 | Any alarm unacknowledged |

## Verification
The bench builds the block with `WORD_W` = 16 and `NUM_WORDS` = 3. That gives 48 alarms, so word boundaries at bits 15/16 and 31/32 and the top bit 47 are all exercised. It also shows that the horn gathers unacknowledged alarms from every word. Directed sequences cover single-cycle traps, a held button, acknowledged alarms that drop and return, and the lamp phase. A long run then applies sparse pseudo-random alarm patterns with random acknowledge and flash strobes, and compares every output against a behavioural model on every clock.

// File: rtl/alm_pkg.sv
package alm_pkg;
  // lamp drive for one alarm: flashing, steady or dark
  function automatic logic lamp_bit(logic unack, logic acked, logic phase);
    return (unack & phase) | acked;
  endfunction
endpackage

// File: rtl/alm_ack_edge.sv
module alm_ack_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic rise_o
);
  logic ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= ack_i;
  end

  assign rise_o = ack_i & ~ack_q;

  // R5
  rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/alm_flasher.sv
module alm_flasher (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic phase_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_o <= 1'b0;
    else if (tick_i) phase_o <= ~phase_o;
  end

  // R8
  phase_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (phase_o != $past(phase_o)));
  // R8
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(phase_o));
endmodule

// File: rtl/alm_word.sv
module alm_word #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] raw_i,
  input  logic              ack_rise_i,
  input  logic              flash_i,
  output logic [WORD_W-1:0] unack_o,
  output logic [WORD_W-1:0] acked_o,
  output logic [WORD_W-1:0] cur_o,
  output logic [WORD_W-1:0] lamp_o,
  output logic              any_unack_o
);
  logic [WORD_W-1:0] unack_q, acked_q, unack_d, acked_d, trapped;

  // new alarms latch until acknowledged
  assign trapped = unack_q | (raw_i & ~acked_q);

  always_comb begin
    if (ack_rise_i) begin
      // copy of current alarms, masked by raw: only still-active ones stay acked
      acked_d = (trapped | raw_i) & raw_i;
      unack_d = '0;
    end else begin
      acked_d = acked_q & raw_i;
      unack_d = trapped;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unack_q <= '0;
      acked_q <= '0;
    end else begin
      unack_q <= unack_d;
      acked_q <= acked_d;
    end
  end

  assign unack_o     = unack_q;
  assign acked_o     = acked_q;
  assign cur_o       = unack_q | acked_q;
  assign any_unack_o = |unack_q;

  for (genvar b = 0; b < WORD_W; b++) begin : g_lamp
    assign lamp_o[b] = alm_pkg::lamp_bit(unack_q[b], acked_q[b], flash_i);
  end

  // R2
  trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_rise_i |=> ((unack_q & $past(raw_i & ~acked_q)) == $past(raw_i & ~acked_q)));
  // R4
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_rise_i |=> (unack_q == '0));
  // R6
  acked_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((acked_q & ~$past(raw_i)) == '0));
  // R3
  exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unack_q & acked_q) == '0);
endmodule

// File: rtl/alm_annunciator.sv
module alm_annunciator #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned NUM_WORDS = 5,
  localparam int unsigned N_ALM    = WORD_W * NUM_WORDS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ALM-1:0] raw_i,
  input  logic             ack_i,
  input  logic             flash_tick_i,
  output logic [N_ALM-1:0] cur_o,
  output logic [N_ALM-1:0] acked_o,
  output logic [N_ALM-1:0] unack_o,
  output logic [N_ALM-1:0] lamp_o,
  output logic             horn_o
);
  logic                 ack_rise, phase;
  logic [NUM_WORDS-1:0] word_any;

  alm_ack_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ack_i  (ack_i),
    .rise_o (ack_rise)
  );

  alm_flasher u_flash (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (flash_tick_i),
    .phase_o (phase)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    alm_word #(.WORD_W(WORD_W)) u_word (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .raw_i       (raw_i[w*WORD_W +: WORD_W]),
      .ack_rise_i  (ack_rise),
      .flash_i     (phase),
      .unack_o     (unack_o[w*WORD_W +: WORD_W]),
      .acked_o     (acked_o[w*WORD_W +: WORD_W]),
      .cur_o       (cur_o[w*WORD_W +: WORD_W]),
      .lamp_o      (lamp_o[w*WORD_W +: WORD_W]),
      .any_unack_o (word_any[w])
    );
  end

  assign horn_o = |word_any;

  // R9
  horn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    horn_o == (unack_o != '0));
  // R7
  lamp_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lamp_o & ~cur_o) == '0);
endmodule

// File: tb/alm_annunciator_bench.sv
`timescale 1ns/1ps
module alm_annunciator_bench;
  localparam int W  = 16;
  localparam int NW = 3;
  localparam int N  = W * NW;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] raw;
  logic         ack, tick;
  logic [N-1:0] cur, acked, unack, lamp;
  logic         horn;

  bit [N-1:0] m_u, m_a;
  bit         m_ph, m_ap;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;
  bit [63:0]  seed = 64'h9E37_79B9_7F4A_7C15;

  always #2.5 clk = ~clk;

  alm_annunciator #(.WORD_W(W), .NUM_WORDS(NW)) u_alm_annunciator (
    .clk_i(clk), .rst_ni(rst_n), .raw_i(raw), .ack_i(ack),
    .flash_tick_i(tick), .cur_o(cur), .acked_o(acked),
    .unack_o(unack), .lamp_o(lamp), .horn_o(horn)
  );

  function automatic bit [63:0] rnd();
    seed ^= seed << 13;
    seed ^= seed >> 7;
    seed ^= seed << 17;
    return seed;
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    bit [N-1:0] exp_lamp;
    exp_lamp = (m_u & {N{m_ph}}) | m_a;
    chk("R2 unack word", unack, m_u);
    chk("R4 acked word", acked, m_a);
    chk("R3 current word", cur, m_u | m_a);
    chk("R7 lamp drive", lamp, exp_lamp);
    chk("R9 horn", {{(N-1){1'b0}}, horn}, {{(N-1){1'b0}}, (m_u != '0)});
  endtask

  // drive at negedge, model after posedge, compare at next negedge
  task automatic step(input bit [N-1:0] r, input bit a, input bit t);
    bit rise;
    raw = r; ack = a; tick = t;
    @(posedge clk);
    rise = a && !m_ap;
    for (int i = 0; i < N; i++) begin
      bit held;
      held = m_u[i] || (r[i] && !m_a[i]);
      if (rise) begin
        m_a[i] = r[i];
        m_u[i] = 1'b0;
      end else begin
        m_a[i] = m_a[i] && r[i];
        m_u[i] = held;
      end
    end
    m_ap = a;
    if (t) m_ph = !m_ph;
    @(negedge clk);
    cmp_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit last_lamp;
    rst_n = 1'b0; raw = '0; ack = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
    // R1 in reset
    chk("R1 unack in reset", unack, '0);
    chk("R1 lamps in reset", lamp, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cur after reset", cur | acked, '0);
    chk("R1 horn after reset", {{(N-1){1'b0}}, horn}, '0);

    // R2: one-cycle pulse trapped
    step(48'h0000_0000_0020, 0, 0);
    step('0, 0, 0);
    step('0, 0, 1);
    chk("R2 single-cycle trap bit5", unack & 48'h20, 48'h20);
    // R7/R8: flashing follows phase
    last_lamp = lamp[5];
    step('0, 0, 1);
    chk("R8 lamp toggles on tick", {{(N-1){1'b0}}, lamp[5]}, {{(N-1){1'b0}}, !last_lamp});
    step('0, 0, 0);
    chk("R8 lamp holds without tick", {{(N-1){1'b0}}, lamp[5]}, {{(N-1){1'b0}}, !last_lamp});
    // R4: ack of cleared alarm -> dark
    step('0, 1, 0);
    step('0, 0, 0);
    chk("R4 cleared alarm acked dark", lamp | unack | acked, '0);

    // R6: active alarm acked -> steady, drop clears, return re-latches
    step(48'h0000_0010_0000, 0, 0);
    step(48'h0000_0010_0000, 1, 0);
    step(48'h0000_0010_0000, 0, 1);
    chk("R7 steady lamp bit20", lamp, 48'h0000_0010_0000);
    step(48'h0000_0010_0000, 0, 1);
    chk("R7 steady across phase", lamp, 48'h0000_0010_0000);
    step('0, 0, 0);
    chk("R6 acked clears on drop", acked, '0);
    step(48'h0000_0010_0000, 0, 0);
    chk("R6 re-raise latches unack", unack, 48'h0000_0010_0000);

    // R5: held button masks nothing new
    step(48'h0000_0010_0000, 1, 0);
    step(48'h0002_0010_0000, 1, 0);
    step(48'h0002_0010_0000, 1, 0);
    chk("R5 alarm during held ack", unack, 48'h0002_0000_0000);
    chk("R5 earlier alarm stays acked", acked, 48'h0000_0010_0000);
    step('0, 0, 0);
    step('0, 1, 0);
    step('0, 0, 0);

    // R10: bits in first and last word
    step(48'h8000_0000_0001, 0, 0);
    chk("R10 both words trapped", unack, 48'h8000_0000_0001);
    step(48'h8000_0000_0001, 1, 0);
    chk("R10 both words acked", acked, 48'h8000_0000_0001);
    step(48'h8000_0000_0000, 0, 0);
    chk("R10 word0 independent", acked, 48'h8000_0000_0000);
    step('0, 0, 0);

    for (int k = 0; k < 600; k++) begin
      bit [N-1:0] r;
      bit [63:0]  x;
      r = rnd() & rnd() & rnd();
      x = rnd();
      step(r, x[3:1] == 3'd0 || (ack && x[4]), x[6:5] == 2'd0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule